// File: doc/BRIEF.md
# Source-Field Substitution Prefix Unit

This unit sits in the execute stage of a simple in-order pipeline that issues one instruction per cycle. When a substitution prefix executes, the unit adds the low field of the prefix's D register value to the prefix's S operand. The S operand is either a register value or the immediate carried in the word. The 9-bit result is held for one instruction and is written over the source field of the next instruction that issues. That next instruction therefore executes with a source field it never carried in memory.

A prefix whose S operand is a register also advances a pointer kept in its own D register. The low field moves by a signed step stored in the next field of the same register, and the unit hands the new value back with a write strobe. A prefix may be followed by another prefix. The second one then executes with its source field already replaced, so a chain of prefixes builds addresses step by step.

The unit also tracks a pending set-Q notification. A set-Q instruction raises the notification, a substitution prefix passes it through untouched, and any other instruction consumes it. Reset and a pipeline flush both discard a patch that has not yet been applied.

Top module: `subst_prefix_unit`

## Requirements
- R1: An instruction word is laid out as opcode in bits [31:19], immediate flag in bit 18, D field in bits [17:9] and S field in bits [8:0]. A word whose opcode equals OP_SUBST (default 13'h0A5) is a substitution prefix, and one equal to OP_SETQ (default 13'h0C1) is a set-Q. Any other value, including one differing by a single bit, is neither.
- R2: For an issued prefix, `src_o` equals D[8:0] plus the S operand, truncated to 9 bits. The S operand is the word's bits [8:0] when bit 18 is 1, and `sreg_i` when bit 18 is 0.
- R3: The next instruction that issues after a prefix appears on `ins_o` with bits [8:0] replaced by that prefix's `src_o`. Bits [31:9] equal `ins_i`.
- R4: A prefix with a register S operand raises `dwr_o`. `dwr_data_o` is then D with bits [8:0] set to D[8:0] + D[17:9], truncated to 9 bits, and bits [31:9] unchanged. The sum is taken after `src_o` is formed from the original D[8:0].
- R5: A prefix with an immediate S operand (bit 18 = 1) leaves `dwr_o` low.
- R6: The step D[17:9] is signed. A step of 9'h1FF moves the pointer down by one, modulo 512.
- R7: When the instruction after a prefix is itself a prefix, that second prefix executes with its S field already patched. For example, D = 32'h601 with register S value 1 gives 2 and writes D[8:0] = 4. A following immediate prefix with D = 32'h604 then gives 6, and the instruction after it sees 6.
- R8: A patch applies to exactly one issued instruction. Cycles with `issue_i` low in between do not drop it, and the instruction after the patched one is unpatched.
- R9: `flush_i` discards any pending patch. It also squashes an instruction issued in the same cycle: that instruction raises no `sub_o`, no `dwr_o`, creates no patch and does not change `qnote_o`.
- R10: After reset, no patch is pending and `qnote_o` is 0.
- R11: An issued set-Q sets `qnote_o` from the next cycle. An issued prefix leaves it set. Any other issued instruction clears it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush_i | input | 1 | Pipeline flush: drops the pending patch and squashes this cycle's instruction |
| issue_i | input | 1 | An instruction executes this cycle |
| ins_i | input | 32 | Fetched word of the executing instruction |
| dval_i | input | 32 | D register value of the executing instruction |
| sreg_i | input | 9 | Low bits of the S register value, read at the patched address |
| ins_o | output | 32 | Executing instruction word after any patch |
| src_o | output | 9 | Substitution value formed by a prefix |
| sub_o | output | 1 | A substitution prefix executes this cycle |
| dwr_o | output | 1 | Write strobe for the D register |
| dwr_data_o | output | 32 | Value to write to the D register |
| qnote_o | output | 1 | Pending set-Q notification |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, 9-bit fields, a 9-bit signed step and opcodes 13'h0A5 and 13'h0C1. Because the step and the field have the same width, a step of all ones reaches the wrap-down case, and sums over 511 reach the truncation case. The encodings are fixed, so an opcode one bit away from the prefix code can be issued to show that decoding is exact. The stimulus table runs chains of prefixes, both immediate and register forms. Directed sequences then cover idle gaps, flushes, reset and the set-Q notification.

// File: rtl/subst_pkg.sv
package subst_pkg;
   // class of the instruction currently in execute
   typedef enum logic [1:0] {
      K_OTHER = 2'd0,
      K_SUBST = 2'd1,
      K_SETQ  = 2'd2
   } ins_kind_e;
endpackage

// File: rtl/subst_decode.sv
module subst_decode
   import subst_pkg::*;
#(
   parameter int OPC_W    = 13,
   parameter int OP_SUBST = 'h0A5,
   parameter int OP_SETQ  = 'h0C1
) (
   input  logic [OPC_W-1:0] opc_i,
   output ins_kind_e        kind_o
);
   localparam logic [OPC_W-1:0] CODE_SUBST = OPC_W'(OP_SUBST);
   localparam logic [OPC_W-1:0] CODE_SETQ  = OPC_W'(OP_SETQ);

   always_comb begin
      if (opc_i == CODE_SUBST)
         kind_o = K_SUBST;
      else if (opc_i == CODE_SETQ)
         kind_o = K_SETQ;
      else
         kind_o = K_OTHER;
   end
endmodule

// File: rtl/subst_arith.sv
module subst_arith #(
   parameter int FLD_W      = 9,
   parameter int INC_W      = 9,
   parameter bit INC_SIGNED = 1'b1
) (
   input  logic [FLD_W-1:0] base_i,
   input  logic [INC_W-1:0] step_i,
   input  logic [FLD_W-1:0] sop_i,
   output logic [FLD_W-1:0] src_o,
   output logic [FLD_W-1:0] base_next_o
);
   localparam int PAD_W = FLD_W - INC_W;

   logic [FLD_W-1:0] step_ext;

   // the step field is widened to the pointer width; the variant is fixed by parameters
   generate
      if (PAD_W == 0) begin : g_same
         assign step_ext = step_i;
      end else if (INC_SIGNED) begin : g_sext
         assign step_ext = {{PAD_W{step_i[INC_W-1]}}, step_i};
      end else begin : g_zext
         assign step_ext = {{PAD_W{1'b0}}, step_i};
      end
   endgenerate

   // both sums start from the original pointer value
   assign src_o       = base_i + sop_i;
   assign base_next_o = base_i + step_ext;
endmodule

// File: rtl/subst_hold.sv
module subst_hold #(
   parameter int FLD_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             load_i,
   input  logic             use_i,
   input  logic [FLD_W-1:0] val_i,
   output logic             pend_o,
   output logic [FLD_W-1:0] val_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
         val_o  <= '0;
      end else if (clear_i) begin
         pend_o <= 1'b0;
      end else if (load_i) begin
         // a prefix that consumed a patch may arm a fresh one in the same cycle
         pend_o <= 1'b1;
         val_o  <= val_i;
      end else if (use_i) begin
         pend_o <= 1'b0;
      end
   end
endmodule

// File: rtl/subst_prefix_unit.sv
module subst_prefix_unit
   import subst_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int FLD_W      = 9,
   parameter int INC_W      = 9,
   parameter bit INC_SIGNED = 1'b1,
   parameter int OP_SUBST   = 'h0A5,
   parameter int OP_SETQ    = 'h0C1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              issue_i,
   input  logic [WORD_W-1:0] ins_i,
   input  logic [WORD_W-1:0] dval_i,
   input  logic [FLD_W-1:0]  sreg_i,
   output logic [WORD_W-1:0] ins_o,
   output logic [FLD_W-1:0]  src_o,
   output logic              sub_o,
   output logic              dwr_o,
   output logic [WORD_W-1:0] dwr_data_o,
   output logic              qnote_o
);
   localparam int IMM_BIT = 2 * FLD_W;
   localparam int OPC_LSB = IMM_BIT + 1;
   localparam int OPC_W   = WORD_W - OPC_LSB;
   localparam int STEP_HI = FLD_W + INC_W - 1;

   initial begin
      assert (OPC_W >= 1)
         else $fatal(1, "word too narrow for opcode, flag and two fields");
      assert (INC_W >= 1 && INC_W <= FLD_W)
         else $fatal(1, "step width must lie in 1..FLD_W");
      assert (STEP_HI < WORD_W)
         else $fatal(1, "step field runs past the register");
      assert (OP_SUBST != OP_SETQ)
         else $fatal(1, "opcodes must differ");
      assert (OP_SUBST >= 0 && OP_SUBST < (1 << OPC_W) && OP_SETQ >= 0 && OP_SETQ < (1 << OPC_W))
         else $fatal(1, "opcode does not fit its field");
   end

   logic             live;
   logic             apply;
   logic             pend_v;
   logic [FLD_W-1:0] pend_val;
   logic             imm;
   logic [FLD_W-1:0] sop;
   logic [FLD_W-1:0] sum;
   logic [FLD_W-1:0] base_next;
   ins_kind_e        kind;

   // an instruction counts only when it issues and is not squashed
   assign live  = issue_i & ~flush_i;
   assign apply = live & pend_v;

   assign ins_o = apply ? {ins_i[WORD_W-1:FLD_W], pend_val} : ins_i;

   subst_decode #(
      .OPC_W   (OPC_W),
      .OP_SUBST(OP_SUBST),
      .OP_SETQ (OP_SETQ)
   ) u_dec (
      .opc_i (ins_o[WORD_W-1:OPC_LSB]),
      .kind_o(kind)
   );

   assign imm = ins_o[IMM_BIT];
   assign sop = imm ? ins_o[FLD_W-1:0] : sreg_i;

   subst_arith #(
      .FLD_W     (FLD_W),
      .INC_W     (INC_W),
      .INC_SIGNED(INC_SIGNED)
   ) u_arith (
      .base_i     (dval_i[FLD_W-1:0]),
      .step_i     (dval_i[STEP_HI:FLD_W]),
      .sop_i      (sop),
      .src_o      (sum),
      .base_next_o(base_next)
   );

   assign sub_o      = live & (kind == K_SUBST);
   assign src_o      = sum;
   assign dwr_o      = sub_o & ~imm;
   assign dwr_data_o = {dval_i[WORD_W-1:FLD_W], base_next};

   subst_hold #(
      .FLD_W(FLD_W)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(flush_i),
      .load_i (sub_o),
      .use_i  (live),
      .val_i  (sum),
      .pend_o (pend_v),
      .val_o  (pend_val)
   );

   // set-Q notification: prefixes are transparent to it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         qnote_o <= 1'b0;
      else if (live) begin
         case (kind)
            K_SETQ:  qnote_o <= 1'b1;
            K_SUBST: qnote_o <= qnote_o;
            default: qnote_o <= 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/subst_prefix_chk.sv
module subst_prefix_chk #(
   parameter int WORD_W = 32,
   parameter int FLD_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush_i,
   input logic              issue_i,
   input logic [WORD_W-1:0] ins_i,
   input logic [WORD_W-1:0] dval_i,
   input logic [WORD_W-1:0] ins_o,
   input logic [FLD_W-1:0]  src_o,
   input logic              sub_o,
   input logic              dwr_o,
   input logic [WORD_W-1:0] dwr_data_o,
   input logic              qnote_o
);
   localparam int IMM_BIT = 2 * FLD_W;

   // R3
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |-> ins_o[WORD_W-1:FLD_W] == ins_i[WORD_W-1:FLD_W]);

   // R3
   patch_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sub_o ##1 (issue_i && !flush_i) |-> ins_o[FLD_W-1:0] == $past(src_o));

   // R5
   imm_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dwr_o |-> !ins_o[IMM_BIT] && sub_o);

   // R4
   wr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dwr_o |-> dwr_data_o[WORD_W-1:FLD_W] == dval_i[WORD_W-1:FLD_W]);

   // R9
   flush_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> !sub_o && !dwr_o);

   // R9
   flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i ##1 (issue_i && !flush_i) |-> ins_o == ins_i);

   // R11
   qkeep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_o && qnote_o) |=> qnote_o);

   // R11
   qidle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> $stable(qnote_o));
endmodule

bind subst_prefix_unit subst_prefix_chk #(
   .WORD_W(WORD_W),
   .FLD_W (FLD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush_i   (flush_i),
   .issue_i   (issue_i),
   .ins_i     (ins_i),
   .dval_i    (dval_i),
   .ins_o     (ins_o),
   .src_o     (src_o),
   .sub_o     (sub_o),
   .dwr_o     (dwr_o),
   .dwr_data_o(dwr_data_o),
   .qnote_o   (qnote_o)
);

// File: tb/sim_subst_prefix_unit.sv
module sim_subst_prefix_unit;
   localparam int CLK_P = 10;
   localparam logic [12:0] OPS = 13'h0A5;
   localparam logic [12:0] OPQ = 13'h0C1;
   localparam logic [12:0] OPM = 13'h011;

   typedef struct packed {
      logic [12:0] op;
      logic        imm;
      logic [8:0]  s;
      logic [31:0] dv;
      logic [8:0]  sr;
      logic [8:0]  es;
      logic        esub;
      logic [8:0]  esrc;
      logic        ewr;
      logic [31:0] ewd;
   } row_t;

   // consecutive issues; each row depends on the patch left by the one before (R2..R7)
   localparam row_t TBL [0:7] = '{
      '{OPS, 1'b0, 9'h005, 32'h0000_0601, 9'h001, 9'h005, 1'b1, 9'h002, 1'b1, 32'h0000_0604},
      '{OPS, 1'b1, 9'h014, 32'h0000_0604, 9'h000, 9'h002, 1'b1, 9'h006, 1'b0, 32'h0},
      '{OPM, 1'b1, 9'h019, 32'h0000_0000, 9'h000, 9'h006, 1'b0, 9'h000, 1'b0, 32'h0},
      '{OPS, 1'b0, 9'h007, 32'h0003_FFFF, 9'h003, 9'h007, 1'b1, 9'h002, 1'b1, 32'h0003_FFFE},
      '{OPM, 1'b0, 9'h009, 32'h0000_0000, 9'h000, 9'h002, 1'b0, 9'h000, 1'b0, 32'h0},
      '{OPS, 1'b1, 9'h1F0, 32'hABC0_0020, 9'h000, 9'h1F0, 1'b1, 9'h010, 1'b0, 32'h0},
      '{OPS, 1'b0, 9'h0AA, 32'h0000_0A03, 9'h005, 9'h010, 1'b1, 9'h008, 1'b1, 32'h0000_0A08},
      '{OPM, 1'b0, 9'h033, 32'h0000_0000, 9'h000, 9'h008, 1'b0, 9'h000, 1'b0, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic        issue_i = 1'b0;
   logic [31:0] ins_i = '0;
   logic [31:0] dval_i = '0;
   logic [8:0]  sreg_i = '0;
   logic [31:0] ins_o;
   logic [8:0]  src_o;
   logic        sub_o;
   logic        dwr_o;
   logic [31:0] dwr_data_o;
   logic        qnote_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   subst_prefix_unit u0 (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .issue_i(issue_i),
      .ins_i(ins_i), .dval_i(dval_i), .sreg_i(sreg_i), .ins_o(ins_o),
      .src_o(src_o), .sub_o(sub_o), .dwr_o(dwr_o), .dwr_data_o(dwr_data_o),
      .qnote_o(qnote_o)
   );

   function automatic logic [31:0] mk(logic [12:0] op, logic imm, logic [8:0] s);
      return {op, imm, 9'h1C3, s};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // drive after the falling edge, settle, then the caller samples before the rising edge
   task automatic put(input logic iss, input logic [31:0] w, input logic [31:0] dv,
                      input logic [8:0] sr, input logic fl);
      @(negedge clk);
      issue_i = iss; ins_i = w; dval_i = dv; sreg_i = sr; flush_i = fl;
      #(CLK_P/4);
   endtask

   task automatic idle();
      put(1'b0, 32'h0, 32'h0, 9'h0, 1'b0);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      idle();
      // R10 reset state
      chk("R10 qnote after reset", 32'(qnote_o), 32'd0);
      chk("R10 no sub when idle", 32'(sub_o), 32'd0);
      chk("R10 no write when idle", 32'(dwr_o), 32'd0);

      // table walk: R2 R3 R4 R5 R6 R7 (first row also checks no patch after reset, R10)
      for (int i = 0; i < 8; i++) begin
         put(1'b1, mk(TBL[i].op, TBL[i].imm, TBL[i].s), TBL[i].dv, TBL[i].sr, 1'b0);
         chk($sformatf("R3 row%0d patched word", i), ins_o,
             mk(TBL[i].op, TBL[i].imm, TBL[i].es));
         chk($sformatf("R1 row%0d sub flag", i), 32'(sub_o), 32'(TBL[i].esub));
         if (TBL[i].esub)
            chk($sformatf("R2 row%0d src", i), 32'(src_o), 32'(TBL[i].esrc));
         chk($sformatf("R4 R5 row%0d write strobe", i), 32'(dwr_o), 32'(TBL[i].ewr));
         if (TBL[i].ewr)
            chk($sformatf("R4 R6 row%0d write data", i), dwr_data_o, TBL[i].ewd);
      end

      // R8 idle gap keeps the patch; one-shot afterwards
      put(1'b1, mk(OPS, 1'b1, 9'h003), 32'h10, 9'h0, 1'b0);
      chk("R2 src imm", 32'(src_o), 32'h13);
      idle(); idle();
      put(1'b1, mk(OPM, 1'b0, 9'h000), 32'h0, 9'h0, 1'b0);
      chk("R8 patch after idle gap", ins_o, mk(OPM, 1'b0, 9'h013));
      put(1'b1, mk(OPM, 1'b0, 9'h044), 32'h0, 9'h0, 1'b0);
      chk("R8 second instruction unpatched", ins_o, mk(OPM, 1'b0, 9'h044));

      // R9 flush in a gap drops the patch
      put(1'b1, mk(OPS, 1'b1, 9'h001), 32'h1, 9'h0, 1'b0);
      put(1'b0, 32'h0, 32'h0, 9'h0, 1'b1);
      put(1'b1, mk(OPM, 1'b0, 9'h055), 32'h0, 9'h0, 1'b0);
      chk("R9 flushed patch dropped", ins_o, mk(OPM, 1'b0, 9'h055));

      // R9 flush squashes a prefix in the same cycle
      put(1'b1, mk(OPS, 1'b0, 9'h002), 32'h601, 9'h004, 1'b1);
      chk("R9 squashed sub flag", 32'(sub_o), 32'd0);
      chk("R9 squashed write", 32'(dwr_o), 32'd0);
      put(1'b1, mk(OPM, 1'b0, 9'h066), 32'h0, 9'h0, 1'b0);
      chk("R9 no patch from squashed prefix", ins_o, mk(OPM, 1'b0, 9'h066));

      // R10 reset discards a pending patch
      put(1'b1, mk(OPS, 1'b1, 9'h00F), 32'h1, 9'h0, 1'b0);
      @(negedge clk); issue_i = 1'b0; rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      put(1'b1, mk(OPM, 1'b0, 9'h077), 32'h0, 9'h0, 1'b0);
      chk("R10 patch cleared by reset", ins_o, mk(OPM, 1'b0, 9'h077));

      // R11 set-Q notification survives a prefix, cleared by another instruction
      put(1'b1, mk(OPQ, 1'b1, 9'h000), 32'h0, 9'h0, 1'b0);
      chk("R11 qnote before set-Q lands", 32'(qnote_o), 32'd0);
      put(1'b1, mk(OPS, 1'b1, 9'h001), 32'h0, 9'h0, 1'b0);
      chk("R11 qnote set", 32'(qnote_o), 32'd1);
      put(1'b1, mk(OPM, 1'b0, 9'h000), 32'h0, 9'h0, 1'b0);
      chk("R11 qnote kept across prefix", 32'(qnote_o), 32'd1);
      idle();
      chk("R11 qnote consumed", 32'(qnote_o), 32'd0);

      // R1 near-miss opcode is not a prefix
      put(1'b1, mk(13'h0A4, 1'b0, 9'h005), 32'h601, 9'h001, 1'b0);
      chk("R1 near-miss sub flag", 32'(sub_o), 32'd0);
      chk("R1 near-miss write", 32'(dwr_o), 32'd0);
      put(1'b1, mk(OPM, 1'b0, 9'h012), 32'h0, 9'h0, 1'b0);
      chk("R1 near-miss leaves no patch", ins_o, mk(OPM, 1'b0, 9'h012));
      idle();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule